// File: doc/BRIEF.md
# Activation Frame Allocator and Local Write Decoder

This block sits at the token input of a dataflow processing element. It receives local control tokens as a pair of 16-bit flits. It manages a small pool of physical operand frames on behalf of up to eight activation identifiers. An allocate token binds an activation identifier to the lowest-numbered idle physical frame. A release token, or a release request from an executing free-frame instruction, returns that frame to the pool.

The same token family carries local writes. A local write either stores the second flit into instruction memory or stores it into a slot of the frame that is currently bound to the token's activation identifier. Writes to frames are resolved through the binding table, so the loader never needs to know which physical frame an activation landed in.

A separate combinational lookup port lets neighbouring logic translate an activation identifier into its physical frame. Loading follows a fixed order: instruction writes first, then allocations, then frame slot writes, then the seed tokens.

Top module: `pe_frame_ctrl`

## Requirements
- R1: After synchronous reset, no activation identifier is bound to a frame, both sticky flags are 0, and neither write strobe is active.
- R2: A token is acted on only if its flit-1 bits [15:13] are 011 and its bits [12:11] equal the PE_ID parameter. Bits [10:9] give the kind: 00 is frame control and 01 is local write. Any other token, including kinds 10 and 11, leaves the table, the flags and the strobes untouched.
- R3: A frame-control token with bit [8]=0 binds the activation identifier in bits [2:0] to the lowest-numbered idle frame. From the next cycle, the lookup port reports a hit with that frame index.
- R4: The lookup port is combinational from the committed table, so a lookup made in the same cycle as an allocation still sees the old binding.
- R5: An allocation is rejected when every frame is busy, or when the identifier is already bound. A rejected allocation leaves the table unchanged and sets the sticky overflow flag.
- R6: A frame-control token with bit [8]=1 releases the frame bound to identifier [2:0]. Releasing an unbound identifier changes nothing.
- R7: The free_req input releases the frame bound to free_act. It may do so in the same cycle as a release token for another identifier, and both take effect.
- R8: A local write with region bit [8]=0 pulses iram_we one cycle later, with iram_addr equal to flit-1 bits [7:3] and iram_data equal to flit 2. The identifier bits are ignored, even when that identifier is unbound.
- R9: A local write with region bit [8]=1 to a bound identifier pulses frm_we one cycle later, with the bound frame index, slot bits [7:3] and the flit-2 data.
- R10: A region-1 write to an unbound identifier produces no frm_we and sets the sticky fault flag.
- R11: Both flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token present this cycle |
| tok_flit1 | input | 16 | Header flit |
| tok_flit2 | input | 16 | Data flit |
| free_req | input | 1 | Release request from a free-frame instruction |
| free_act | input | 3 | Identifier to release |
| lk_act | input | 3 | Lookup identifier |
| lk_hit | output | 1 | Identifier is bound |
| lk_frame | output | FRAME_W | Bound frame index |
| iram_we | output | 1 | Instruction memory write strobe |
| iram_addr | output | 5 | Instruction memory address |
| iram_data | output | 16 | Instruction word |
| frm_we | output | 1 | Frame slot write strobe |
| frm_idx | output | FRAME_W | Physical frame written |
| frm_slot | output | 5 | Slot written |
| frm_data | output | 16 | Slot data |
| ovf_flag | output | 1 | Sticky rejected-allocation flag |
| fault_flag | output | 1 | Sticky unbound-write flag |

## Verification
The hardest situations to reach are the ones where the table is being reused. One is an allocation that lands in a hole left by an earlier release rather than in the next frame in sequence. The other is two releases that arrive together from different sources. The stimulus reaches them by filling every frame, releasing a middle frame, and then allocating a new identifier while the lookup port is watching it. It then fires a release token and a free_req for different identifiers in the same cycle. A reference table kept in the bench predicts every frame index from the lowest-idle rule.

// File: rtl/fm_pkg.sv
package fm_pkg;
    localparam int ACT_W  = 3;
    localparam int SLOT_W = 5;
    localparam int DATA_W = 16;
    localparam int PE_W   = 2;
    localparam int NUM_ACT = 1 << ACT_W;

    localparam logic [2:0] PREFIX_LOCAL = 3'b011;
    localparam logic [1:0] KIND_CTRL    = 2'b00;
    localparam logic [1:0] KIND_WRITE   = 2'b01;

    typedef struct packed {
        logic              alloc;
        logic              release_f;
        logic              iram_wr;
        logic              frm_wr;
        logic [SLOT_W-1:0] slot;
        logic [ACT_W-1:0]  act;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic cmd_t decode_tok(input logic v,
                                        input logic [15:0] f1,
                                        input logic [15:0] f2,
                                        input logic [PE_W-1:0] pe);
        cmd_t c;
        c = '0;
        if (v && f1[15:13] == PREFIX_LOCAL && f1[12:11] == pe) begin
            case (f1[10:9])
                KIND_CTRL: begin
                    c.alloc     = !f1[8];
                    c.release_f = f1[8];
                end
                KIND_WRITE: begin
                    c.iram_wr = !f1[8];
                    c.frm_wr  = f1[8];
                end
                default: ;
            endcase
        end
        c.slot = f1[7:3];
        c.act  = f1[2:0];
        c.data = f2;
        return c;
    endfunction
endpackage

// File: rtl/fm_lookup.sv
module fm_lookup
    import fm_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic [NUM_FRAMES-1:0]            vld,
    input  logic [NUM_FRAMES-1:0][ACT_W-1:0] owner,
    input  logic [ACT_W-1:0]                 act,
    output logic                             hit,
    output logic [FRAME_W-1:0]               frame
);
    always_comb begin
        hit   = 1'b0;
        frame = '0;
        for (int f = NUM_FRAMES - 1; f >= 0; f--) begin
            if (vld[f] && owner[f] == act) begin
                hit   = 1'b1;
                frame = FRAME_W'(f);
            end
        end
    end
endmodule

// File: rtl/fm_table.sv
module fm_table
    import fm_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             alloc,
    input  logic [ACT_W-1:0]                 alloc_act,
    input  logic                             rel_a,
    input  logic [ACT_W-1:0]                 rel_a_act,
    input  logic                             rel_b,
    input  logic [ACT_W-1:0]                 rel_b_act,
    output logic                             alloc_reject,
    output logic [NUM_FRAMES-1:0]            vld,
    output logic [NUM_FRAMES-1:0][ACT_W-1:0] owner
);
    logic               already;
    logic               any_idle;
    logic [FRAME_W-1:0] idle_idx;
    logic               dup_frame;

    fm_lookup #(.NUM_FRAMES(NUM_FRAMES)) u_self (
        .vld(vld), .owner(owner), .act(alloc_act),
        .hit(already), .frame(dup_frame_idx)
    );
    logic [FRAME_W-1:0] dup_frame_idx;
    assign dup_frame = already;

    always_comb begin
        any_idle = 1'b0;
        idle_idx = '0;
        for (int f = NUM_FRAMES - 1; f >= 0; f--) begin
            if (!vld[f]) begin
                any_idle = 1'b1;
                idle_idx = FRAME_W'(f);
            end
        end
    end

    assign alloc_reject = alloc && (dup_frame || !any_idle);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld   <= '0;
            owner <= '0;
        end else begin
            for (int f = 0; f < NUM_FRAMES; f++) begin
                if (vld[f] && ((rel_a && owner[f] == rel_a_act) ||
                               (rel_b && owner[f] == rel_b_act)))
                    vld[f] <= 1'b0;
            end
            if (alloc && !alloc_reject) begin
                vld[idle_idx]   <= 1'b1;
                owner[idle_idx] <= alloc_act;
            end
        end
    end
endmodule

// File: rtl/pe_frame_ctrl.sv
module pe_frame_ctrl
    import fm_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    parameter logic [PE_W-1:0] PE_ID = 2'd1,
    localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tok_valid,
    input  logic [15:0]        tok_flit1,
    input  logic [15:0]        tok_flit2,
    input  logic               free_req,
    input  logic [ACT_W-1:0]   free_act,
    input  logic [ACT_W-1:0]   lk_act,
    output logic               lk_hit,
    output logic [FRAME_W-1:0] lk_frame,
    output logic               iram_we,
    output logic [SLOT_W-1:0]  iram_addr,
    output logic [DATA_W-1:0]  iram_data,
    output logic               frm_we,
    output logic [FRAME_W-1:0] frm_idx,
    output logic [SLOT_W-1:0]  frm_slot,
    output logic [DATA_W-1:0]  frm_data,
    output logic               ovf_flag,
    output logic               fault_flag
);
    cmd_t                             cmd;
    logic                             alloc_reject;
    logic [NUM_FRAMES-1:0]            tbl_vld;
    logic [NUM_FRAMES-1:0][ACT_W-1:0] tbl_owner;
    logic                             wr_hit;
    logic [FRAME_W-1:0]               wr_frame;

    assign cmd = decode_tok(tok_valid, tok_flit1, tok_flit2, PE_ID);

    fm_table #(.NUM_FRAMES(NUM_FRAMES)) u_table (
        .clk(clk), .rst(rst),
        .alloc(cmd.alloc), .alloc_act(cmd.act),
        .rel_a(cmd.release_f), .rel_a_act(cmd.act),
        .rel_b(free_req), .rel_b_act(free_act),
        .alloc_reject(alloc_reject),
        .vld(tbl_vld), .owner(tbl_owner)
    );

    fm_lookup #(.NUM_FRAMES(NUM_FRAMES)) u_wr_lk (
        .vld(tbl_vld), .owner(tbl_owner), .act(cmd.act),
        .hit(wr_hit), .frame(wr_frame)
    );

    fm_lookup #(.NUM_FRAMES(NUM_FRAMES)) u_ext_lk (
        .vld(tbl_vld), .owner(tbl_owner), .act(lk_act),
        .hit(lk_hit), .frame(lk_frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            iram_we    <= 1'b0;
            iram_addr  <= '0;
            iram_data  <= '0;
            frm_we     <= 1'b0;
            frm_idx    <= '0;
            frm_slot   <= '0;
            frm_data   <= '0;
            ovf_flag   <= 1'b0;
            fault_flag <= 1'b0;
        end else begin
            iram_we <= cmd.iram_wr;
            frm_we  <= cmd.frm_wr && wr_hit;
            if (cmd.iram_wr) begin
                iram_addr <= cmd.slot;
                iram_data <= cmd.data;
            end
            if (cmd.frm_wr && wr_hit) begin
                frm_idx  <= wr_frame;
                frm_slot <= cmd.slot;
                frm_data <= cmd.data;
            end
            if (alloc_reject)
                ovf_flag <= 1'b1;
            if (cmd.frm_wr && !wr_hit)
                fault_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/fm_checker.sv
module fm_checker
    import fm_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    parameter logic [PE_W-1:0] PE_ID = 2'd1
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             tok_valid,
    input logic [15:0]                      tok_flit1,
    input logic [15:0]                      tok_flit2,
    input logic                             free_req,
    input logic                             iram_we,
    input logic [SLOT_W-1:0]                iram_addr,
    input logic [DATA_W-1:0]                iram_data,
    input logic                             frm_we,
    input logic                             ovf_flag,
    input logic                             fault_flag,
    input logic [NUM_FRAMES-1:0]            tbl_vld,
    input logic [NUM_FRAMES-1:0][ACT_W-1:0] tbl_owner
);
    logic mine;
    logic dup;
    assign mine = tok_valid && tok_flit1[15:13] == 3'b011 && tok_flit1[12:11] == PE_ID;

    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < NUM_FRAMES; i++)
            for (int j = i + 1; j < NUM_FRAMES; j++)
                if (tbl_vld[i] && tbl_vld[j] && tbl_owner[i] == tbl_owner[j])
                    dup = 1'b1;
    end

    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    a_r11_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        fault_flag |=> fault_flag);

    a_r2_foreign_quiet: assert property (@(posedge clk) disable iff (rst)
        !mine |=> !iram_we && !frm_we);

    a_r8_iram_write: assert property (@(posedge clk) disable iff (rst)
        (mine && tok_flit1[10:9] == 2'b01 && !tok_flit1[8])
        |=> iram_we && !frm_we && iram_data == $past(tok_flit2)
            && iram_addr == $past(tok_flit1[7:3]));

    a_r5_unique_owner: assert property (@(posedge clk) disable iff (rst)
        !dup);

    a_r5_full_reject: assert property (@(posedge clk) disable iff (rst)
        (mine && tok_flit1[10:8] == 3'b000 && (&tbl_vld) && !free_req)
        |=> $stable(tbl_vld) && $stable(tbl_owner) && ovf_flag);
endmodule

bind pe_frame_ctrl fm_checker #(.NUM_FRAMES(NUM_FRAMES), .PE_ID(PE_ID)) u_chk (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_flit1(tok_flit1),
    .tok_flit2(tok_flit2), .free_req(free_req), .iram_we(iram_we),
    .iram_addr(iram_addr), .iram_data(iram_data), .frm_we(frm_we),
    .ovf_flag(ovf_flag), .fault_flag(fault_flag),
    .tbl_vld(tbl_vld), .tbl_owner(tbl_owner)
);

// File: tb/tb_pe_frame_ctrl.sv
module tb_pe_frame_ctrl;
    localparam int NF = 4;
    localparam logic [1:0] MYPE = 2'd1;

    logic        clk = 1'b0;
    logic        rst;
    logic        tok_valid;
    logic [15:0] tok_flit1, tok_flit2;
    logic        free_req;
    logic [2:0]  free_act, lk_act;
    logic        lk_hit;
    logic [1:0]  lk_frame;
    logic        iram_we;
    logic [4:0]  iram_addr;
    logic [15:0] iram_data;
    logic        frm_we;
    logic [1:0]  frm_idx;
    logic [4:0]  frm_slot;
    logic [15:0] frm_data;
    logic        ovf_flag, fault_flag;

    int nchk = 0;
    int nerr = 0;
    int mdl_frame [8];
    bit mdl_busy [NF];

    always #5 clk = ~clk;

    pe_frame_ctrl #(.NUM_FRAMES(NF), .PE_ID(MYPE)) dut (.*);

    function automatic logic [15:0] f_ctrl(input logic [1:0] pe, input logic op, input logic [2:0] a);
        return {3'b011, pe, 2'b00, op, 5'b0, a};
    endfunction

    function automatic logic [15:0] f_wr(input logic [1:0] pe, input logic rg,
                                         input logic [4:0] s, input logic [2:0] a);
        return {3'b011, pe, 2'b01, rg, s, a};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic tok(input logic [15:0] f1, input logic [15:0] f2);
        @(negedge clk);
        tok_valid = 1'b1; tok_flit1 = f1; tok_flit2 = f2;
        @(posedge clk); #1;
        tok_valid = 1'b0;
    endtask

    task automatic check_map(input string req);
        for (int a = 0; a < 8; a++) begin
            lk_act = 3'(a);
            #1;
            chk(req, {31'b0, lk_hit}, {31'b0, mdl_frame[a] >= 0});
            if (mdl_frame[a] >= 0)
                chk(req, {30'b0, lk_frame}, 32'(mdl_frame[a]));
        end
    endtask

    function automatic int lowest_idle();
        for (int f = 0; f < NF; f++) if (!mdl_busy[f]) return f;
        return -1;
    endfunction

    task automatic m_alloc(input int a);
        int f;
        f = lowest_idle();
        if (mdl_frame[a] < 0 && f >= 0) begin
            mdl_frame[a] = f; mdl_busy[f] = 1'b1;
        end
    endtask

    task automatic m_free(input int a);
        if (mdl_frame[a] >= 0) begin
            mdl_busy[mdl_frame[a]] = 1'b0; mdl_frame[a] = -1;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        nerr++; nchk++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int a = 0; a < 8; a++) mdl_frame[a] = -1;
        for (int f = 0; f < NF; f++) mdl_busy[f] = 1'b0;
        tok_valid = 0; tok_flit1 = 0; tok_flit2 = 0;
        free_req = 0; free_act = 0; lk_act = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check_map("R1");
        chk("R1", {30'b0, ovf_flag, fault_flag}, 0);
        chk("R1", {30'b0, iram_we, frm_we}, 0);

        // R8 instruction writes, act field ignored
        for (int s = 0; s < 32; s++) begin
            logic [15:0] d;
            d = 16'((s * 16'h0101) ^ 16'h00A5);
            tok(f_wr(MYPE, 1'b0, 5'(s), 3'(s)), d);
            chk("R8", {31'b0, iram_we}, 1);
            chk("R8", {27'b0, iram_addr}, 32'(s));
            chk("R8", {16'b0, iram_data}, {16'b0, d});
            chk("R8", {31'b0, frm_we}, 0);
        end
        chk("R8", {31'b0, fault_flag}, 0);

        // R2 foreign or unknown tokens
        for (int p = 0; p < 4; p++) begin
            if (2'(p) != MYPE) begin
                tok(f_ctrl(2'(p), 1'b0, 3'd3), 16'h1);
                chk("R2", {30'b0, iram_we, frm_we}, 0);
                tok(f_wr(2'(p), 1'b0, 5'd4, 3'd0), 16'h2);
                chk("R2", {30'b0, iram_we, frm_we}, 0);
            end
        end
        tok({3'b010, MYPE, 2'b01, 1'b0, 5'd1, 3'd0}, 16'h3);
        chk("R2", {30'b0, iram_we, frm_we}, 0);
        tok({3'b011, MYPE, 2'b10, 1'b0, 5'd1, 3'd0}, 16'h4);
        chk("R2", {30'b0, iram_we, frm_we}, 0);
        tok({3'b011, MYPE, 2'b11, 1'b1, 5'd1, 3'd0}, 16'h5);
        chk("R2", {30'b0, iram_we, frm_we}, 0);
        check_map("R2");
        chk("R2", {30'b0, ovf_flag, fault_flag}, 0);

        // R10 write to unbound act
        tok(f_wr(MYPE, 1'b1, 5'd3, 3'd2), 16'hBEEF);
        chk("R10", {31'b0, frm_we}, 0);
        chk("R10", {31'b0, fault_flag}, 1);

        // R3 allocation order
        tok(f_ctrl(MYPE, 1'b0, 3'd5), 0); m_alloc(5);
        chk("R3", {31'b0, ovf_flag}, 0);
        check_map("R3");
        // R5 duplicate
        tok(f_ctrl(MYPE, 1'b0, 3'd5), 0);
        chk("R5", {31'b0, ovf_flag}, 1);
        check_map("R5");
        tok(f_ctrl(MYPE, 1'b0, 3'd1), 0); m_alloc(1);
        tok(f_ctrl(MYPE, 1'b0, 3'd7), 0); m_alloc(7);
        tok(f_ctrl(MYPE, 1'b0, 3'd0), 0); m_alloc(0);
        check_map("R3");

        // R9 frame writes sweep
        for (int a = 0; a < 8; a++) begin
            if (mdl_frame[a] >= 0) begin
                for (int s = 0; s < 32; s++) begin
                    logic [15:0] d;
                    d = 16'((a << 8) ^ (s * 37) ^ 16'h5A00);
                    tok(f_wr(MYPE, 1'b1, 5'(s), 3'(a)), d);
                    chk("R9", {31'b0, frm_we}, 1);
                    chk("R9", {30'b0, frm_idx}, 32'(mdl_frame[a]));
                    chk("R9", {27'b0, frm_slot}, 32'(s));
                    chk("R9", {16'b0, frm_data}, {16'b0, d});
                    chk("R9", {31'b0, iram_we}, 0);
                end
            end
        end

        // R5 full pool
        tok(f_ctrl(MYPE, 1'b0, 3'd3), 0);
        chk("R5", {31'b0, ovf_flag}, 1);
        check_map("R5");

        // R6 release
        tok(f_ctrl(MYPE, 1'b1, 3'd1), 0); m_free(1);
        check_map("R6");
        tok(f_ctrl(MYPE, 1'b1, 3'd4), 0);
        check_map("R6");

        // R4 lookup in allocation cycle
        @(negedge clk);
        lk_act = 3'd4;
        tok_valid = 1'b1; tok_flit1 = f_ctrl(MYPE, 1'b0, 3'd4); tok_flit2 = 0;
        #1;
        chk("R4", {31'b0, lk_hit}, 0);
        @(posedge clk); #1;
        tok_valid = 1'b0;
        m_alloc(4);
        chk("R4", {31'b0, lk_hit}, 1);
        chk("R4", {30'b0, lk_frame}, 32'(mdl_frame[4]));

        // R7 instruction release, then simultaneous releases
        @(negedge clk);
        free_req = 1'b1; free_act = 3'd7;
        @(posedge clk); #1;
        free_req = 1'b0; m_free(7);
        check_map("R7");
        @(negedge clk);
        free_req = 1'b1; free_act = 3'd5;
        tok_valid = 1'b1; tok_flit1 = f_ctrl(MYPE, 1'b1, 3'd0); tok_flit2 = 0;
        @(posedge clk); #1;
        free_req = 1'b0; tok_valid = 1'b0;
        m_free(5); m_free(0);
        check_map("R7");
        tok(f_ctrl(MYPE, 1'b0, 3'd6), 0); m_alloc(6);
        check_map("R7");

        // R11 flags persist until reset
        chk("R11", {30'b0, ovf_flag, fault_flag}, 3);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        for (int a = 0; a < 8; a++) mdl_frame[a] = -1;
        for (int f = 0; f < NF; f++) mdl_busy[f] = 1'b0;
        chk("R11", {30'b0, ovf_flag, fault_flag}, 0);
        check_map("R1");

        finish_run();
    end
endmodule